// File: doc/BRIEF.md
# System Clock Source Select and Divider

This block controls the system clock of a small controller. An 8-bit control register picks one of four oscillators as the undivided clock source. It also applies a power-of-two divide from 1 to 128 to that source. Each oscillator is modelled as a clock-enable input in the single `clk_i` domain. A cycle in which the active source's enable is high is one undivided tick. The block produces a divided clock-enable output, `clk_en_o`, and a one-hot view of the active source.

A seven-bit phase counter runs freely on undivided ticks. A newly written divide code is held pending until that counter wraps to zero, so every divide change lands on an aligned boundary. A read-only ready bit reports whether the written divide is in effect.

Source changes are made glitch-free. The switch is committed only after a tick of the old oscillator and a tick of the new one have both been seen, which bounds the wait to one period of the slower of the two. While a switch is pending, `clk_en_o` is held low.

Top module: `sysclk_ctrl`

## Requirements
- R1: After reset the register reads 0x34: ready bit 7 is 0, divide code 011, bit 3 is 0 and source code 100. `src_sel_o` is 4'b1000, the low-power source.
- R2: Bits 6:4 hold the divide code N, from 0 to 7. Once it applies, `clk_en_o` pulses on exactly one of every 2^N undivided ticks, so 256 ticks give 256>>N pulses. With N=0 it is high on every tick.
- R3: A written divide code takes effect only at the tick where the phase counter wraps from 127 to 0, which is at most 128 undivided ticks after the write.
- R4: Bit 7 reads 0 in the cycle after any register write. It becomes 1 when the pending divide is loaded and stays 1 until the next write.
- R5: Bit 3 always reads 0, and writing a 1 to it has no effect.
- R6: Source codes map onto `src_sel_o` and `src_en_i` as follows: 000 selects index 0 (precision), 001 selects index 1 (external), 011 selects index 2 (real-time) and any code with bit 2 set selects index 3 (low power).
- R7: Writing the reserved source code 010 leaves the active source unchanged, and bits 2:0 keep returning the last active legal code.
- R8: A switch to a different source completes only after at least one tick of the old source and one of the new source have been seen since the write. Until then bits 2:0 and `src_sel_o` show the old source.
- R9: `clk_en_o` is low while a source switch is pending. It is asserted only in a cycle where the active source's enable is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast reference clock; all logic runs on it |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_en_i | input | 4 | Per-oscillator tick enables: index 0 precision, 1 external, 2 real-time, 3 low power |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register readback: {ready, divide code, 0, source code} |
| src_sel_o | output | 4 | One-hot active source |
| clk_en_o | output | 1 | Divided clock enable |

## Verification
The bench sweeps all eight divide codes and counts enable pulses over 256 ticks. A decoder that was off by one, or a mask that was built wrong, would give a pulse count off by a factor of two. For every divide write it also measures the time from the write to the ready bit. A design that loaded without waiting for the wrap, or that never set ready, would either break the 128-tick bound or never report ready.

Source handling is tested in three ways. A switch is issued toward an oscillator whose enable is held low. A design that switched early, or let enables through while the switch was pending, would show the new source or stray pulses. The reserved code and a write to the unused bit must leave the readback unchanged.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int NUM_SRC = 4;
  localparam int REG_W   = 8;

  typedef enum logic [1:0] {
    SRC_PREC = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_RTC  = 2'd2,
    SRC_LP   = 2'd3
  } src_e;

  localparam logic [2:0] CODE_RSVD   = 3'b010;
  localparam logic [2:0] RST_SRC_CODE = 3'b100;
  localparam logic [2:0] RST_DIV_CODE = 3'b011;

  function automatic logic code_legal(logic [2:0] c);
    return c != CODE_RSVD;
  endfunction

  function automatic src_e code_to_src(logic [2:0] c);
    src_e s;
    if (c[2]) s = SRC_LP;
    else begin
      case (c[1:0])
        2'b00:   s = SRC_PREC;
        2'b01:   s = SRC_EXT;
        2'b11:   s = SRC_RTC;
        default: s = SRC_LP;
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/sysclk_phase.sv
module sysclk_phase #(
  parameter int PH_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  output logic [PH_W-1:0] cnt_o,
  output logic            wrap_o
);
  localparam logic [PH_W-1:0] CNT_MAX = {PH_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end

  // wrap: this tick takes the counter back to zero
  assign wrap_o = tick_i && (cnt_o == CNT_MAX);
endmodule

// File: rtl/sysclk_div_ctrl.sv
module sysclk_div_ctrl #(
  parameter int PH_W  = 7,
  parameter int DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [DIV_W-1:0] code_i,
  input  logic             tick_i,
  input  logic             wrap_i,
  input  logic [PH_W-1:0]  cnt_i,
  input  logic             hold_i,
  output logic [DIV_W-1:0] req_code_o,
  output logic             ready_o,
  output logic             en_o
);
  import sysclk_pkg::*;

  logic [DIV_W-1:0] act_code;
  logic             pend;
  logic [PH_W-1:0]  mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_code_o <= DIV_W'(RST_DIV_CODE);
      act_code   <= DIV_W'(RST_DIV_CODE);
      pend       <= 1'b1;
      ready_o    <= 1'b0;
    end else if (wr_i) begin
      // write wins over a coincident wrap
      req_code_o <= code_i;
      pend       <= 1'b1;
      ready_o    <= 1'b0;
    end else if (pend && wrap_i) begin
      act_code <= req_code_o;
      pend     <= 1'b0;
      ready_o  <= 1'b1;
    end
  end

  always_comb mask = ~({PH_W{1'b1}} << act_code);

  assign en_o = tick_i && !hold_i && ((cnt_i & mask) == mask);
endmodule

// File: rtl/sysclk_src_sw.sv
module sysclk_src_sw #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic               wr_i,
  input  logic [2:0]         code_i,
  output logic [2:0]         code_o,
  output logic [NUM_SRC-1:0] sel_o,
  output logic               tick_o,
  output logic               pend_o
);
  import sysclk_pkg::*;

  logic [2:0] tgt_code;
  logic       seen_old, seen_new;
  src_e       act_src, tgt_src, wr_src;
  logic       old_hit, new_hit;

  always_comb begin
    act_src = code_to_src(code_o);
    tgt_src = code_to_src(tgt_code);
    wr_src  = code_to_src(code_i);
    old_hit = seen_old || en_i[act_src];
    new_hit = seen_new || en_i[tgt_src];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o   <= RST_SRC_CODE;
      tgt_code <= RST_SRC_CODE;
      pend_o   <= 1'b0;
      seen_old <= 1'b0;
      seen_new <= 1'b0;
    end else if (wr_i && code_legal(code_i)) begin
      if (wr_src == act_src) begin
        // same oscillator: relabel, drop any pending switch
        code_o <= code_i;
        pend_o <= 1'b0;
      end else begin
        tgt_code <= code_i;
        pend_o   <= 1'b1;
        seen_old <= 1'b0;
        seen_new <= 1'b0;
      end
    end else if (pend_o) begin
      if (old_hit && new_hit) begin
        code_o <= tgt_code;
        pend_o <= 1'b0;
      end
      seen_old <= old_hit;
      seen_new <= new_hit;
    end
  end

  always_comb begin
    sel_o          = '0;
    sel_o[act_src] = 1'b1;
  end

  assign tick_o = en_i[act_src];
endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl #(
  parameter int PH_W = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] src_en_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic [3:0] src_sel_o,
  output logic       clk_en_o
);
  import sysclk_pkg::*;

  localparam int DIV_W = 3;

  logic [PH_W-1:0]  cnt;
  logic             wrap, tick, pend;
  logic [2:0]       src_code;
  logic [DIV_W-1:0] div_code;
  logic             ready;

  sysclk_src_sw #(.NUM_SRC(NUM_SRC)) u_src (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (src_en_i),
    .wr_i   (wr_en_i),
    .code_i (wr_data_i[2:0]),
    .code_o (src_code),
    .sel_o  (src_sel_o),
    .tick_o (tick),
    .pend_o (pend)
  );

  sysclk_phase #(.PH_W(PH_W)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  sysclk_div_ctrl #(.PH_W(PH_W), .DIV_W(DIV_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_en_i),
    .code_i     (wr_data_i[6:4]),
    .tick_i     (tick),
    .wrap_i     (wrap),
    .cnt_i      (cnt),
    .hold_i     (pend),
    .req_code_o (div_code),
    .ready_o    (ready),
    .en_o       (clk_en_o)
  );

  assign rd_data_o = {ready, div_code, 1'b0, src_code};
endmodule

// File: rtl/sysclk_ctrl_chk.sv
module sysclk_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] src_en_i,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] rd_data_o,
  input logic [3:0] src_sel_o,
  input logic       clk_en_o
);
  AST_WR_CLEARS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !rd_data_o[7]); // R4
  AST_READY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[7] && !wr_en_i |=> rd_data_o[7]); // R4
  AST_UNUSED_BIT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[3]); // R5
  AST_SRC_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(src_sel_o) == 1); // R6
  AST_NO_RSVD_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[2:0] != 3'b010); // R7
  AST_EN_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |-> (src_sel_o & src_en_i) != 4'b0); // R9
endmodule

bind sysclk_ctrl sysclk_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .src_en_i  (src_en_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .rd_data_o (rd_data_o),
  .src_sel_o (src_sel_o),
  .clk_en_o  (clk_en_o)
);

// File: tb/sysclk_ctrl_tb.sv
module sysclk_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] src_en_i = 4'hF;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic [3:0] src_sel_o;
  logic       clk_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  sysclk_ctrl u_dut (.*);

  always #10 clk_i = ~clk_i;

  localparam int VEC_CODE [8] = '{0, 1, 2, 3, 4, 5, 6, 7};
  localparam int VEC_EXP  [8] = '{256, 128, 64, 32, 16, 8, 4, 2};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); #2;
  endtask

  task automatic reg_write(input logic [7:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!rd_data_o[7] && n < 200) begin step(); n++; end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int n, pulses;
    logic [7:0] prev;
    #25 rst_ni = 1'b1;
    #1;
    // R1 reset state
    check(rd_data_o == 8'h34, "R1 readback", rd_data_o, 8'h34);
    check(src_sel_o == 4'b1000, "R1 src_sel", src_sel_o, 4'b1000);
    step();
    // R3 initial load within one window
    wait_ready(n);
    check(rd_data_o[7] && n <= 128, "R3 reset load", n, 128);

    // R2 R3 R4 table of divide codes
    for (int i = 0; i < 8; i++) begin
      reg_write({1'b0, 3'(VEC_CODE[i]), 4'b0100});
      check(!rd_data_o[7], "R4 ready cleared", rd_data_o[7], 0);
      wait_ready(n);
      check(rd_data_o[7] && n <= 128, "R3 load latency", n, 128);
      pulses = 0;
      for (int k = 0; k < 256; k++) begin
        if (clk_en_o) pulses++;
        step();
      end
      check(pulses == VEC_EXP[i], "R2 pulse count", pulses, VEC_EXP[i]);
      check(rd_data_o[7], "R4 ready holds", rd_data_o[7], 1);
    end

    // R2 divide by one: every tick, none without tick
    reg_write(8'h04);
    wait_ready(n);
    src_en_i = 4'b0111; #1;
    check(!clk_en_o, "R9 no tick no enable", clk_en_o, 0);
    src_en_i = 4'hF; #1;
    check(clk_en_o, "R2 div1 every tick", clk_en_o, 1);
    step();

    // R5 unused bit
    reg_write(8'h0C);
    check(rd_data_o[3] == 1'b0 && rd_data_o[2:0] == 3'b100, "R5 bit3", rd_data_o, 8'h04);

    // R6 source code mapping
    reg_write(8'h00); step();
    check(src_sel_o == 4'b0001, "R6 code 000", src_sel_o, 4'b0001);
    reg_write(8'h03); step();
    check(src_sel_o == 4'b0100 && rd_data_o[2:0] == 3'b011, "R6 code 011", src_sel_o, 4'b0100);
    reg_write(8'h05); step();
    check(src_sel_o == 4'b1000 && rd_data_o[2:0] == 3'b101, "R6 code 101", src_sel_o, 4'b1000);

    // R7 reserved code ignored
    prev = rd_data_o;
    reg_write(8'h02); step(); step();
    check(src_sel_o == 4'b1000, "R7 src kept", src_sel_o, 4'b1000);
    check(rd_data_o[2:0] == prev[2:0], "R7 code kept", rd_data_o[2:0], prev[2:0]);

    // R8 R9 switch to external while its enable is low
    wait_ready(n);
    src_en_i = 4'b1101;
    reg_write(8'h01);
    for (int k = 0; k < 6; k++) begin
      #1;
      if (clk_en_o) pulses = -1;
      step();
    end
    check(pulses != -1, "R9 held low while pending", clk_en_o, 0);
    check(src_sel_o == 4'b1000 && rd_data_o[2:0] == 3'b101, "R8 not yet switched", src_sel_o, 4'b1000);
    src_en_i = 4'b1111;
    step();
    src_en_i = 4'b1101;
    #1;
    check(src_sel_o == 4'b0010 && rd_data_o[2:0] == 3'b001, "R8 switched", src_sel_o, 4'b0010);
    check(!clk_en_o, "R9 follows new source", clk_en_o, 0);
    src_en_i = 4'hF;
    step();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule